// File: doc/BRIEF.md
# Shadowed Working/Persistent Register Bank

This block keeps the settings of a small multi-channel output stage. It holds one 8-bit data register per channel and one 8-bit mute/power-down control register. Every register exists twice: a working copy that drives the outputs and a persistent copy that models storage surviving a power cycle. A serial front end decodes each bus transaction and hands the block a commit strobe with a two-bit copy selector, a four-bit register code and a data byte. It also passes the bus STOP event, and it reads values back through a separate combinational read port.

The selector writes the working copy only, the persistent copy only, or both. Its fourth value copies the persistent copy into the working copy without using the data byte. A persistent write makes the block busy from the commit until a programmable number of cycles after the next STOP. While it is busy, further persistent writes are refused and flagged, so the front end can not-acknowledge them.

After a power-cycle reset, the working copies load from the persistent copies in the first clocked cycle. A separate factory reset clears the persistent copies to zero.

Top module: `shadow_regbank`

## Requirements
- R1: A commit with selector 01 writes the data byte into the working copy at the clock edge of the commit. Register codes 0..3 select channels 0..3 and code 4 selects the control register. In the cycle after a channel's working copy is written, that channel's bit of `ch_upd_o` is high for one cycle.
- R2: Selector 10 writes only the persistent copy; the working copy and the outputs keep their values.
- R3: Selector 11 writes the data byte into both copies of the chosen register in the same edge.
- R4: Selector 00 copies the persistent copy into the working copy of the chosen register. The data byte is ignored, and a channel's update strobe pulses as in R1.
- R5: Register code 15 with selector 01 writes the data byte into all four channel working copies and pulses all four update strobes.
- R6: Register codes 5..14 with any selector, and code 15 with any selector other than 01, change no copy and raise neither `nv_reject_o` nor `busy_o`.
- R7: The read port returns the working copy for selector 01 and the persistent copy for selector 10, for codes 0..4. Any other selector or code returns 00 hex.
- R8: While `rst_n` is low, all working copies are 00 hex and `busy_o` is high. In the first clocked cycle after release, every working copy takes its persistent value, commands in that cycle are ignored, and `busy_o` is still high.
- R9: While `nv_rst_n` is low, all persistent copies, including the control register, are 00 hex.
- R10: An accepted persistent write (selector 10 or 11) sets `busy_o` from the next cycle. `busy_o` stays high until a `bus_stop` is sampled, and then for exactly `BUSY_CYCLES` more cycles.
- R11: While busy, a commit with selector 10 or 11 to a valid code raises `nv_reject_o` in the same cycle and writes neither copy. Selector 01 and 00 commits are still accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-cycle reset, active low; clears working copies and starts the load |
| nv_rst_n | input | 1 | Factory reset of the persistent copies, active low |
| cmd_valid | input | 1 | Commit strobe for one decoded command |
| cmd_sel | input | 2 | Copy selector: 00 transfer, 01 working, 10 persistent, 11 both |
| cmd_reg | input | 4 | Register code |
| cmd_data | input | 8 | Data byte |
| bus_stop | input | 1 | STOP seen on the bus; starts the busy interval after a persistent write |
| rd_sel | input | 2 | Read selector: 01 working, 10 persistent |
| rd_reg | input | 4 | Read register code |
| rd_data | output | 8 | Read-back value (combinational) |
| ch_o | output | 32 | Working channel values, channel 0 in the low byte |
| ctl_o | output | 8 | Working mute/power-down control value |
| ch_upd_o | output | 4 | One-cycle per-channel change strobes |
| busy_o | output | 1 | Load or persistent write in progress |
| nv_reject_o | output | 1 | Current persistent-target commit is refused (combinational) |

## Verification
The bench applies each selector value to channel codes, the control code and the broadcast code. It compares which copy changed, so a swapped selector bit or a broadcast leaking into the persistent copies shows up. Persistent-target commits are issued before, during and after the busy interval. This separates a refusal that also suppresses the paired working write from one that suppresses only the persistent half, and it pins the exact cycle `busy_o` falls after STOP. Undefined codes, power-cycle reloads and factory clears are then mixed into a long random run with random read-back of both copies.

// File: rtl/shadow_regbank_pkg.sv
package shadow_regbank_pkg;
    typedef enum logic [1:0] {
        SEL_XFER = 2'b00,
        SEL_WK   = 2'b01,
        SEL_NV   = 2'b10,
        SEL_BOTH = 2'b11
    } sel_e;

    localparam logic [3:0] REG_CTL = 4'd4;
    localparam logic [3:0] REG_ALL = 4'hF;
endpackage

// File: rtl/shadow_cmd_decode.sv
module shadow_cmd_decode
    import shadow_regbank_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int NREG  = NUM_CH + 1
) (
    input  logic            valid_i,
    input  logic [1:0]      sel_i,
    input  logic [3:0]      reg_i,
    output logic [NREG-1:0] tgt_o,
    output logic            wr_wk_o,
    output logic            wr_nv_o,
    output logic            xfer_o
);
    logic bcast;
    logic any_tgt;

    assign bcast = (reg_i == REG_ALL) && (sel_i == SEL_WK);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        assign tgt_o[i] = bcast || (reg_i == 4'(i));
    end
    assign tgt_o[NUM_CH] = (reg_i == REG_CTL);

    assign any_tgt = valid_i && (tgt_o != '0);
    assign wr_wk_o = any_tgt && sel_i[0];
    assign wr_nv_o = any_tgt && sel_i[1];
    assign xfer_o  = any_tgt && (sel_i == SEL_XFER);
endmodule

// File: rtl/nv_busy_timer.sv
module nv_busy_timer #(
    parameter int BUSY_CYCLES = 1_500_000,
    localparam int CW = $clog2(BUSY_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i) begin
            cnt_d = CW'(BUSY_CYCLES);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/shadow_regbank.sv
module shadow_regbank
    import shadow_regbank_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int DW          = 8,
    parameter int BUSY_CYCLES = 1_500_000,
    localparam int NREG       = NUM_CH + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 nv_rst_n,
    input  logic                 cmd_valid,
    input  logic [1:0]           cmd_sel,
    input  logic [3:0]           cmd_reg,
    input  logic [DW-1:0]        cmd_data,
    input  logic                 bus_stop,
    input  logic [1:0]           rd_sel,
    input  logic [3:0]           rd_reg,
    output logic [DW-1:0]        rd_data,
    output logic [NUM_CH*DW-1:0] ch_o,
    output logic [DW-1:0]        ctl_o,
    output logic [NUM_CH-1:0]    ch_upd_o,
    output logic                 busy_o,
    output logic                 nv_reject_o
);
    typedef logic [NREG-1:0][DW-1:0] bank_t;

    typedef struct packed {
        bank_t             regs;
        logic [NUM_CH-1:0] upd;
        logic              pend;
        logic              load;
    } wk_state_t;

    wk_state_t wk_d, wk_q;
    bank_t     nv_d, nv_q;

    logic [NREG-1:0] dec_tgt;
    logic            dec_wk, dec_nv, dec_xfer;
    logic            tmr_start, tmr_busy, nv_busy, reject;

    shadow_cmd_decode #(.NUM_CH(NUM_CH)) dec_i (
        .valid_i (cmd_valid),
        .sel_i   (cmd_sel),
        .reg_i   (cmd_reg),
        .tgt_o   (dec_tgt),
        .wr_wk_o (dec_wk),
        .wr_nv_o (dec_nv),
        .xfer_o  (dec_xfer)
    );

    nv_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) tmr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (tmr_start),
        .busy_o  (tmr_busy)
    );

    assign tmr_start = wk_q.pend && bus_stop;
    assign nv_busy   = wk_q.pend || tmr_busy;

    always_comb begin
        wk_d     = wk_q;
        nv_d     = nv_q;
        wk_d.upd = '0;
        reject   = 1'b0;
        if (tmr_start) wk_d.pend = 1'b0;
        if (wk_q.load) begin
            wk_d.load = 1'b0;
            wk_d.regs = nv_q;
        end else begin
            reject = dec_nv && nv_busy;
            if (!reject) begin
                for (int i = 0; i < NREG; i++) begin
                    if (dec_tgt[i]) begin
                        if (dec_wk)   wk_d.regs[i] = cmd_data;
                        if (dec_xfer) wk_d.regs[i] = nv_q[i];
                        if (dec_nv)   nv_d[i]      = cmd_data;
                    end
                end
                for (int i = 0; i < NUM_CH; i++) begin
                    wk_d.upd[i] = dec_tgt[i] && (dec_wk || dec_xfer);
                end
                if (dec_nv) wk_d.pend = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wk_q      <= '0;
            wk_q.load <= 1'b1;
        end else begin
            wk_q <= wk_d;
        end
    end

    always_ff @(posedge clk or negedge nv_rst_n) begin
        if (!nv_rst_n) nv_q <= '0;
        else           nv_q <= nv_d;
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (rd_reg == 4'(i)) begin
                if (rd_sel == SEL_WK) rd_data = wk_q.regs[i];
                if (rd_sel == SEL_NV) rd_data = nv_q[i];
            end
        end
        if (rd_reg == REG_CTL) begin
            if (rd_sel == SEL_WK) rd_data = wk_q.regs[NUM_CH];
            if (rd_sel == SEL_NV) rd_data = nv_q[NUM_CH];
        end
    end

    assign ch_o        = wk_q.regs[NUM_CH-1:0];
    assign ctl_o       = wk_q.regs[NUM_CH];
    assign ch_upd_o    = wk_q.upd;
    assign busy_o      = wk_q.load || nv_busy;
    assign nv_reject_o = reject;
endmodule

// File: rtl/shadow_regbank_chk.sv
module shadow_regbank_chk #(
    parameter int NUM_CH = 4,
    parameter int DW     = 8,
    localparam int NREG  = NUM_CH + 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 nv_rst_n,
    input logic                 cmd_valid,
    input logic [3:0]           cmd_reg,
    input logic                 bus_stop,
    input logic [NUM_CH*DW-1:0] ch_o,
    input logic [DW-1:0]        ctl_o,
    input logic [NUM_CH-1:0]    ch_upd_o,
    input logic                 busy_o,
    input logic                 nv_reject_o,
    input logic                 load_i,
    input logic                 pend_i,
    input logic [NREG*DW-1:0]   nv_i
);
    p_load_copies_r8: assert property (@(posedge clk) disable iff (!rst_n || !nv_rst_n)
        load_i |=> (ch_o == $past(nv_i[NUM_CH*DW-1:0])) && (ctl_o == $past(nv_i[NREG*DW-1 -: DW])));

    p_reject_keeps_nv_r11: assert property (@(posedge clk) disable iff (!rst_n || !nv_rst_n)
        nv_reject_o |=> nv_i == $past(nv_i));

    p_reject_when_busy_r11: assert property (@(posedge clk) disable iff (!rst_n || !nv_rst_n)
        nv_reject_o |-> busy_o);

    p_undef_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n || !nv_rst_n)
        (cmd_valid && !load_i && (cmd_reg >= 4'd5) && (cmd_reg <= 4'd14))
        |=> $stable(ch_o) && $stable(ctl_o) && $stable(nv_i));

    p_change_strobed_r1: assert property (@(posedge clk) disable iff (!rst_n || !nv_rst_n)
        (!$past(load_i) && (ch_o != $past(ch_o))) |-> (ch_upd_o != '0));

    p_busy_after_stop_r10: assert property (@(posedge clk) disable iff (!rst_n || !nv_rst_n)
        (pend_i && bus_stop) |=> busy_o);
endmodule

bind shadow_regbank shadow_regbank_chk #(.NUM_CH(NUM_CH), .DW(DW)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .nv_rst_n    (nv_rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_reg     (cmd_reg),
    .bus_stop    (bus_stop),
    .ch_o        (ch_o),
    .ctl_o       (ctl_o),
    .ch_upd_o    (ch_upd_o),
    .busy_o      (busy_o),
    .nv_reject_o (nv_reject_o),
    .load_i      (wk_q.load),
    .pend_i      (wk_q.pend),
    .nv_i        (nv_q)
);

// File: tb/shadow_regbank_tb_top.sv
module shadow_regbank_tb_top;
    localparam int NUM_CH = 4;
    localparam int DW     = 8;
    localparam int BUSY   = 20;

    logic        clk = 1'b0;
    logic        rst_n, nv_rst_n, cmd_valid, bus_stop;
    logic [1:0]  cmd_sel, rd_sel;
    logic [3:0]  cmd_reg, rd_reg;
    logic [7:0]  cmd_data, rd_data, ctl_o;
    logic [31:0] ch_o;
    logic [3:0]  ch_upd_o;
    logic        busy_o, nv_reject_o;

    int n_vec = 0;
    int n_err = 0;

    logic [7:0] m_wk [5];
    logic [7:0] m_nv [5];
    bit         m_load, m_pend;
    int         m_cnt;
    logic [3:0] m_upd;

    always #5 clk = ~clk;

    shadow_regbank #(.NUM_CH(NUM_CH), .DW(DW), .BUSY_CYCLES(BUSY)) dut_i (
        .clk(clk), .rst_n(rst_n), .nv_rst_n(nv_rst_n), .cmd_valid(cmd_valid),
        .cmd_sel(cmd_sel), .cmd_reg(cmd_reg), .cmd_data(cmd_data), .bus_stop(bus_stop),
        .rd_sel(rd_sel), .rd_reg(rd_reg), .rd_data(rd_data), .ch_o(ch_o), .ctl_o(ctl_o),
        .ch_upd_o(ch_upd_o), .busy_o(busy_o), .nv_reject_o(nv_reject_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd(input logic [1:0] s, input logic [3:0] r);
        if (r > 4'd4) return 8'h00;
        if (s == 2'b01) return m_wk[r];
        if (s == 2'b10) return m_nv[r];
        return 8'h00;
    endfunction

    function automatic bit code_ok(input logic [1:0] s, input logic [3:0] r);
        return (r <= 4'd4) || (r == 4'hF && s == 2'b01);
    endfunction

    task automatic check_outs(input string req);
        chk(req, ch_o, {m_wk[3], m_wk[2], m_wk[1], m_wk[0]});
        chk(req, ctl_o, m_wk[4]);
        chk(req, ch_upd_o, m_upd);
        chk(req, busy_o, m_load || m_pend || (m_cnt != 0));
    endtask

    // One clock of stimulus; starts and ends at a falling edge.
    task automatic step(input bit v, input logic [1:0] s, input logic [3:0] r,
                        input logic [7:0] d, input bit stp, input string req);
        bit rej, start, hit;
        cmd_valid = v; cmd_sel = s; cmd_reg = r; cmd_data = d; bus_stop = stp;
        rd_sel = 2'($urandom); rd_reg = ($urandom % 3 == 0) ? 4'($urandom) : 4'($urandom % 5);
        #1;
        rej = v && !m_load && code_ok(s, r) && s[1] && (m_pend || m_cnt != 0);
        chk({req, "/R11 reject"}, nv_reject_o, rej);
        chk("R7 read", rd_data, exp_rd(rd_sel, rd_reg));
        @(posedge clk);
        m_upd = '0;
        start = m_pend && stp;
        if (start) begin m_pend = 0; m_cnt = BUSY; end
        else if (m_cnt > 0) m_cnt--;
        if (m_load) begin
            for (int k = 0; k < 5; k++) m_wk[k] = m_nv[k];
            m_load = 0;
        end else if (v && code_ok(s, r) && !rej) begin
            for (int k = 0; k < 5; k++) begin
                hit = (r == 4'hF) ? (k < 4) : (r == 4'(k));
                if (hit) begin
                    if (s[0])        m_wk[k] = d;
                    if (s == 2'b00)  m_wk[k] = m_nv[k];
                    if (s[1])        m_nv[k] = d;
                    if (k < 4 && (s[0] || s == 2'b00)) m_upd[k] = 1'b1;
                end
            end
            if (s[1]) m_pend = 1;
        end
        @(negedge clk);
        cmd_valid = 0; bus_stop = 0;
        check_outs(req);
    endtask

    task automatic idle(input int n, input string req);
        for (int i = 0; i < n; i++) step(0, 2'b00, 4'd0, 8'h00, 0, req);
    endtask

    task automatic power_cycle(input bit factory, input string req);
        @(negedge clk);
        rst_n = 0;
        if (factory) nv_rst_n = 0;
        @(negedge clk);
        @(negedge clk);
        for (int k = 0; k < 5; k++) begin
            m_wk[k] = 8'h00;
            if (factory) m_nv[k] = 8'h00;
        end
        m_load = 1; m_pend = 0; m_cnt = 0; m_upd = '0;
        check_outs({req, " in reset"});
        rst_n = 1; nv_rst_n = 1;
        // Command during the load cycle must be ignored (R8).
        step(1, 2'b01, 4'd0, 8'hEE, 0, {req, " load"});
    endtask

    initial begin
        #1_500_000;
        n_err++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 0; nv_rst_n = 0; cmd_valid = 0; bus_stop = 0;
        cmd_sel = 0; cmd_reg = 0; cmd_data = 0; rd_sel = 0; rd_reg = 0;
        for (int k = 0; k < 5; k++) begin m_wk[k] = 0; m_nv[k] = 0; end
        m_load = 1; m_pend = 0; m_cnt = 0; m_upd = '0;
        @(negedge clk);
        @(negedge clk);
        check_outs("R8 R9 reset");
        rd_sel = 2'b10; rd_reg = 4'd4; #1;
        chk("R9 ctl persistent", rd_data, 8'h00);
        @(negedge clk);
        rst_n = 1; nv_rst_n = 1;
        step(0, 2'b00, 4'd0, 8'h00, 0, "R8 load");

        step(1, 2'b01, 4'd0, 8'h11, 0, "R1 ch0");
        step(1, 2'b01, 4'd1, 8'h22, 0, "R1 ch1");
        step(1, 2'b01, 4'd2, 8'h33, 0, "R1 ch2");
        step(1, 2'b01, 4'd3, 8'h44, 0, "R1 ch3");
        step(1, 2'b01, 4'd4, 8'h55, 0, "R1 ctl");
        step(1, 2'b10, 4'd2, 8'hA5, 0, "R2 nv only");
        step(1, 2'b10, 4'd3, 8'h99, 0, "R11 nv busy");
        step(1, 2'b01, 4'd3, 8'h66, 0, "R11 wk busy");
        step(1, 2'b11, 4'd1, 8'h98, 0, "R11 both busy");
        idle(3, "R10 hold");
        step(0, 2'b00, 4'd0, 8'h00, 1, "R10 stop");
        idle(BUSY + 2, "R10 count");
        step(1, 2'b00, 4'd2, 8'hFF, 0, "R4 xfer");
        step(1, 2'b11, 4'd4, 8'hC3, 0, "R3 both");
        step(0, 2'b00, 4'd0, 8'h00, 1, "R10 stop2");
        idle(BUSY, "R10 count2");
        step(1, 2'b01, 4'hF, 8'h77, 0, "R5 all");
        step(1, 2'b01, 4'd7, 8'h12, 0, "R6 code7");
        step(1, 2'b10, 4'hF, 8'h34, 0, "R6 all nv");
        step(1, 2'b00, 4'hF, 8'h56, 0, "R6 all xfer");
        step(1, 2'b11, 4'd14, 8'h78, 0, "R6 code14");
        rd_sel = 2'b11; rd_reg = 4'd0; #1;
        chk("R7 bad sel", rd_data, 8'h00);
        rd_sel = 2'b10; rd_reg = 4'd2; #1;
        chk("R7 nv ch2", rd_data, 8'hA5);
        @(negedge clk);
        power_cycle(0, "R8 power cycle");
        power_cycle(1, "R9 factory");

        for (int i = 0; i < 1500; i++) begin
            int pick;
            logic [3:0] r;
            pick = $urandom % 8;
            r = (pick < 5) ? 4'(pick) : (pick == 5) ? 4'hF : 4'($urandom);
            step(($urandom % 4) != 0, 2'($urandom), r, 8'($urandom),
                 ($urandom % 6) == 0, "R1-random");
            if (i % 500 == 499) power_cycle(0, "R8 random");
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end
endmodule